// File: doc/BRIEF.md
# Thermal Threshold Interrupt Unit

This unit watches an 8-bit temperature code that an on-chip sensor delivers with a sample strobe. It compares each accepted code against three programmable rising thresholds and three programmable falling thresholds. When the code crosses a threshold in the watched direction, the unit latches a pending event. Software enables a subset of the six event kinds, and a single interrupt line is raised while any enabled event is pending. Software clears pending events by writing ones to a clear register.

The highest of the three rising levels is also the hardware shutdown level. A separate level output requests an emergency shutdown whenever the sensing core and the trip function are both enabled and the last accepted code is at or above that level. A 3-bit sensor selector from the control register is driven out to the analog side. Software reaches every register through a simple single-cycle register bus with a word index. Reads are combinational and writes take effect at the clock edge.

Top module: `thermal_irq_unit`

## Requirements
- R1: After reset every register reads zero, and `irq` and `trip` are low.
- R2: The control register (word 0) holds the sensing-core enable in bit 0, the trip enable in bit 12 and the sensor selector in bits 22:20. It reads back only those bits, and `sensor_sel` follows bits 22:20.
- R3: The rising-threshold register (word 2) holds level 0 in bits 15:8, level 1 in bits 23:16 and the shutdown level (level 2) in bits 31:24. Bits 7:0 read zero. The falling-threshold register (word 3) uses the same byte positions per level and stores all 32 bits.
- R4: The status register (word 1) returns in bits 7:0 the code of the last accepted sample. A sample is accepted when `smp_valid` is high while the core enable is set. All other status bits read zero.
- R5: The rising event of level i sets pending bit 4*i (bits 0, 4, 8). It is set on an accepted sample whose code is at or above that level's rising threshold when the previous accepted sample was below it, or when there was no previous accepted sample since reset.
- R6: The falling event of level i sets pending bit 16+4*i (bits 16, 20, 24). It is set on an accepted sample whose code is below that level's falling threshold when the previous accepted sample was at or above it.
- R7: While the core enable is clear, samples are ignored: the status code, the crossing history and the pending bits do not change.
- R8: Pending bits (read at word 5) are latched regardless of the enable register. `irq` is high exactly while some pending bit has its enable bit set.
- R9: Writing ones to the clear register (word 6, same six bit positions) clears those pending bits. An event that sets a bit in the same cycle as its clear leaves the bit set.
- R10: `trip` is high exactly while the core enable and the trip enable are both set and the status code is at or above the shutdown level.
- R11: The enable register (word 4) stores only bits 0, 4, 8, 16, 20 and 24. All its other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the index |
| smp_valid | input | 1 | Sensor sample strobe |
| smp_code | input | 8 | Sensor temperature code |
| sensor_sel | output | 3 | Sensor input selector from control bits 22:20 |
| irq | output | 1 | Combined interrupt |
| trip | output | 1 | Hardware shutdown request level |

## Verification
A sample or a register write presented in one cycle is captured at the next rising edge. The status code, the pending bits, `irq` and `trip` all reflect it right after that edge, and readback is combinational. The bench therefore drives every stimulus at a falling edge, holds it over exactly one rising edge, and compares readback and outputs at the following falling edge against its model. The simultaneous event-and-clear case is driven in one single cycle so that both act on the same edge.

// File: rtl/tti_pkg.sv
package tti_pkg;

  localparam int CODE_W  = 8;
  localparam int NUM_LVL = 3;
  localparam int NUM_EVT = 2 * NUM_LVL;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 3;

  localparam int CORE_BIT = 0;
  localparam int TRIP_BIT = 12;
  localparam int SEL_LSB  = 20;
  localparam int SEL_W    = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 3'd0,
    REG_STAT = 3'd1,
    REG_RISE = 3'd2,
    REG_FALL = 3'd3,
    REG_EN   = 3'd4,
    REG_PEND = 3'd5,
    REG_CLR  = 3'd6
  } reg_idx_e;

  // Bit position of compact event k in the enable/pending/clear layout.
  // Events 0..NUM_LVL-1 are rising, the rest falling.
  function automatic int evt_pos(input int k);
    if (k < NUM_LVL) return 4 * k;
    return 16 + 4 * (k - NUM_LVL);
  endfunction

  // Least significant bit of level i inside a threshold register.
  function automatic int thr_lsb(input int i);
    return 8 + CODE_W * i;
  endfunction

endpackage

// File: rtl/tti_regs.sv
module tti_regs
  import tti_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_sel,
  input  logic                            bus_wr,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [DATA_W-1:0]               bus_wdata,
  output logic [DATA_W-1:0]               bus_rdata,
  input  logic [CODE_W-1:0]               stat_code,
  input  logic [NUM_EVT-1:0]              pend_evt,
  output logic                            core_en,
  output logic                            trip_en,
  output logic [SEL_W-1:0]                sensor_sel,
  output logic [NUM_LVL-1:0][CODE_W-1:0]  rise_thr,
  output logic [NUM_LVL-1:0][CODE_W-1:0]  fall_thr,
  output logic [NUM_EVT-1:0]              en_evt,
  output logic [NUM_EVT-1:0]              clr_evt
);

  logic                           core_q, core_d;
  logic                           trip_q, trip_d;
  logic [SEL_W-1:0]               sel_q, sel_d;
  logic [NUM_LVL-1:0][CODE_W-1:0] rise_q, rise_d;
  logic [DATA_W-1:0]              fall_q, fall_d;
  logic [NUM_EVT-1:0]             en_q, en_d;
  logic                           wr_hit;
  logic [NUM_EVT-1:0]             wdata_evt;

  assign wr_hit = bus_sel & bus_wr;

  always_comb begin
    for (int k = 0; k < NUM_EVT; k++) wdata_evt[k] = bus_wdata[evt_pos(k)];
  end

  // next-state
  always_comb begin
    core_d  = core_q;
    trip_d  = trip_q;
    sel_d   = sel_q;
    rise_d  = rise_q;
    fall_d  = fall_q;
    en_d    = en_q;
    clr_evt = '0;
    if (wr_hit) begin
      case (reg_idx_e'(bus_addr))
        REG_CTRL: begin
          core_d = bus_wdata[CORE_BIT];
          trip_d = bus_wdata[TRIP_BIT];
          sel_d  = bus_wdata[SEL_LSB +: SEL_W];
        end
        REG_RISE: begin
          for (int i = 0; i < NUM_LVL; i++) rise_d[i] = bus_wdata[thr_lsb(i) +: CODE_W];
        end
        REG_FALL: fall_d  = bus_wdata;
        REG_EN:   en_d    = wdata_evt;
        REG_CLR:  clr_evt = wdata_evt;
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_q <= 1'b0;
      trip_q <= 1'b0;
      sel_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      en_q   <= '0;
    end else begin
      core_q <= core_d;
      trip_q <= trip_d;
      sel_q  <= sel_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
      en_q   <= en_d;
    end
  end

  assign core_en    = core_q;
  assign trip_en    = trip_q;
  assign sensor_sel = sel_q;
  assign rise_thr   = rise_q;
  assign en_evt     = en_q;

  generate
    for (genvar i = 0; i < NUM_LVL; i++) begin : g_fall
      assign fall_thr[i] = fall_q[thr_lsb(i) +: CODE_W];
    end
  endgenerate

  // readback
  always_comb begin
    bus_rdata = '0;
    case (reg_idx_e'(bus_addr))
      REG_CTRL: begin
        bus_rdata[CORE_BIT]            = core_q;
        bus_rdata[TRIP_BIT]            = trip_q;
        bus_rdata[SEL_LSB +: SEL_W]    = sel_q;
      end
      REG_STAT: bus_rdata[CODE_W-1:0] = stat_code;
      REG_RISE: begin
        for (int i = 0; i < NUM_LVL; i++) bus_rdata[thr_lsb(i) +: CODE_W] = rise_q[i];
      end
      REG_FALL: bus_rdata = fall_q;
      REG_EN: begin
        for (int k = 0; k < NUM_EVT; k++) bus_rdata[evt_pos(k)] = en_q[k];
      end
      REG_PEND: begin
        for (int k = 0; k < NUM_EVT; k++) bus_rdata[evt_pos(k)] = pend_evt[k];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/tti_level_det.sv
module tti_level_det #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_ok,
  input  logic [CODE_W-1:0] code,
  input  logic [CODE_W-1:0] rise_thr,
  input  logic [CODE_W-1:0] fall_thr,
  output logic              rise_evt,
  output logic              fall_evt
);

  logic at_rise, at_fall;
  logic hist_r_q, hist_r_d;
  logic hist_f_q, hist_f_d;

  assign at_rise = (code >= rise_thr);
  assign at_fall = (code >= fall_thr);

  assign rise_evt = smp_ok &  at_rise & ~hist_r_q;
  assign fall_evt = smp_ok & ~at_fall &  hist_f_q;

  // next-state: history only moves on accepted samples
  always_comb begin
    hist_r_d = hist_r_q;
    hist_f_d = hist_f_q;
    if (smp_ok) begin
      hist_r_d = at_rise;
      hist_f_d = at_fall;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_r_q <= 1'b0;
      hist_f_q <= 1'b0;
    end else begin
      hist_r_q <= hist_r_d;
      hist_f_q <= hist_f_d;
    end
  end

  // R5: a rising crossing cannot repeat on the very next cycle
  assert_no_double_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> !rise_evt);

  // R6: a falling crossing cannot repeat on the very next cycle
  assert_no_double_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> !fall_evt);

endmodule

// File: rtl/tti_pending.sv
module tti_pending #(
  parameter int NUM_EVT = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               core_en,
  input  logic [NUM_EVT-1:0] set_evt,
  input  logic [NUM_EVT-1:0] clr_evt,
  input  logic [NUM_EVT-1:0] en_evt,
  output logic [NUM_EVT-1:0] pend,
  output logic               irq
);

  logic [NUM_EVT-1:0] pend_q, pend_d;

  // next-state: set wins over clear in the same cycle
  always_comb begin
    pend_d = (pend_q & ~clr_evt) | set_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;
  assign irq  = |(pend_q & en_evt);

  generate
    for (genvar k = 0; k < NUM_EVT; k++) begin : g_chk
      // R8: pending holds until cleared, whatever the enables do
      assert_pend_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q[k] && !clr_evt[k]) |=> pend_q[k]);
      // R9: a clear without a coinciding set empties the bit
      assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt[k] && !set_evt[k]) |=> !pend_q[k]);
      // R9: a set is never lost, even against a clear
      assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt[k] |=> pend_q[k]);
      // R7: events only arise with the core enabled
      assert_set_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt[k] |-> core_en);
    end
  endgenerate

endmodule

// File: rtl/thermal_irq_unit.sv
module thermal_irq_unit
  import tti_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              smp_valid,
  input  logic [7:0]        smp_code,
  output logic [2:0]        sensor_sel,
  output logic              irq,
  output logic              trip
);

  localparam int TRIP_LVL = NUM_LVL - 1;

  // reset: asserted at once, released through two flops
  logic rst_ff1, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_ff1 <= 1'b0;
      rst_s   <= 1'b0;
    end else begin
      rst_ff1 <= 1'b1;
      rst_s   <= rst_ff1;
    end
  end

  logic                           core_en, trip_en, smp_ok;
  logic [NUM_LVL-1:0][CODE_W-1:0] rise_thr, fall_thr;
  logic [NUM_EVT-1:0]             en_evt, clr_evt, set_evt, pend_evt;
  logic [NUM_LVL-1:0]             rise_evt, fall_evt;
  logic [CODE_W-1:0]              code_q, code_d;

  assign smp_ok = smp_valid & core_en;

  tti_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_s),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .stat_code  (code_q),
    .pend_evt   (pend_evt),
    .core_en    (core_en),
    .trip_en    (trip_en),
    .sensor_sel (sensor_sel),
    .rise_thr   (rise_thr),
    .fall_thr   (fall_thr),
    .en_evt     (en_evt),
    .clr_evt    (clr_evt)
  );

  generate
    for (genvar i = 0; i < NUM_LVL; i++) begin : g_lvl
      tti_level_det #(.CODE_W(CODE_W)) u_det (
        .clk      (clk),
        .rst_n    (rst_s),
        .smp_ok   (smp_ok),
        .code     (smp_code),
        .rise_thr (rise_thr[i]),
        .fall_thr (fall_thr[i]),
        .rise_evt (rise_evt[i]),
        .fall_evt (fall_evt[i])
      );
      assign set_evt[i]           = rise_evt[i];
      assign set_evt[NUM_LVL + i] = fall_evt[i];
    end
  endgenerate

  tti_pending #(.NUM_EVT(NUM_EVT)) u_pend (
    .clk     (clk),
    .rst_n   (rst_s),
    .core_en (core_en),
    .set_evt (set_evt),
    .clr_evt (clr_evt),
    .en_evt  (en_evt),
    .pend    (pend_evt),
    .irq     (irq)
  );

  // status code: next-state and register
  always_comb begin
    code_d = code_q;
    if (smp_ok) code_d = smp_code;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) code_q <= '0;
    else        code_q <= code_d;
  end

  assign trip = core_en & trip_en & (code_q >= rise_thr[TRIP_LVL]);

  // R4/R7: status code only moves on an accepted sample
  assert_stat_hold_R4: assert property (@(posedge clk) disable iff (!rst_s)
    !(smp_valid && core_en) |=> $stable(code_q));

  // R10: no trip request without the core running
  assert_trip_needs_core_R10: assert property (@(posedge clk) disable iff (!rst_s)
    !core_en |-> !trip);

endmodule

// File: tb/thermal_irq_unit_tb.sv
module thermal_irq_unit_tb;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        smp_valid;
  logic [7:0]  smp_code;
  logic [2:0]  sensor_sel;
  logic        irq, trip;

  always #(CLK_PERIOD/2) clk = ~clk;

  thermal_irq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .smp_valid(smp_valid), .smp_code(smp_code), .sensor_sel(sensor_sel),
    .irq(irq), .trip(trip)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model
  bit        m_core, m_trip;
  bit [2:0]  m_sel;
  bit [7:0]  m_rise [3];
  bit [31:0] m_fall;
  bit [31:0] m_en, m_pend;
  bit [7:0]  m_code;
  bit        m_hr [3];
  bit        m_hf [3];

  localparam bit [31:0] EVT_MASK = 32'h0111_0111;

  function automatic bit [31:0] exp_read(input int idx);
    case (idx)
      0: return {9'd0, m_sel, 7'd0, m_trip, 11'd0, m_core};
      1: return {24'd0, m_code};
      2: return {m_rise[2], m_rise[1], m_rise[0], 8'd0};
      3: return m_fall;
      4: return m_en;
      5: return m_pend;
      default: return 32'd0;
    endcase
  endfunction

  function automatic bit exp_irq();
    return |(m_pend & m_en);
  endfunction

  function automatic bit exp_trip();
    return m_core && m_trip && (m_code >= m_rise[2]);
  endfunction

  function automatic bit [7:0] fall_lvl(input int i);
    return m_fall[8 + 8*i +: 8];
  endfunction

  task automatic model_write(input int idx, input bit [31:0] d, input bit evt_same);
    case (idx)
      0: begin m_core = d[0]; m_trip = d[12]; m_sel = d[22:20]; end
      2: begin m_rise[0] = d[15:8]; m_rise[1] = d[23:16]; m_rise[2] = d[31:24]; end
      3: m_fall = d;
      4: m_en = d & EVT_MASK;
      6: m_pend = m_pend & ~(d & EVT_MASK);
      default: ;
    endcase
    if (evt_same) ; // placeholder for symmetry with sample-time ordering
  endtask

  task automatic model_sample(input bit [7:0] c);
    if (!m_core) return;
    for (int i = 0; i < 3; i++) begin
      bit ar, af;
      ar = (c >= m_rise[i]);
      af = (c >= fall_lvl(i));
      if (ar && !m_hr[i]) m_pend[4*i] = 1'b1;
      if (!af && m_hf[i]) m_pend[16 + 4*i] = 1'b1;
      m_hr[i] = ar;
      m_hf[i] = af;
    end
    m_code = c;
  endtask

  task automatic check(input string req, input bit [31:0] got, input bit [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic bus_write(input int idx, input bit [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'(idx); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    model_write(idx, d, 1'b0);
  endtask

  task automatic bus_read(input int idx, output bit [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 3'(idx);
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic sample(input bit [7:0] c);
    @(negedge clk);
    smp_valid = 1'b1; smp_code = c;
    @(negedge clk);
    smp_valid = 1'b0;
    model_sample(c);
  endtask

  task automatic check_reg(input string req, input int idx);
    bit [31:0] d;
    bus_read(idx, d);
    check(req, d, exp_read(idx));
  endtask

  task automatic check_outs(input string req);
    check({req, " irq"},  {31'd0, irq},  {31'd0, exp_irq()});
    check({req, " trip"}, {31'd0, trip}, {31'd0, exp_trip()});
  endtask

  function automatic void model_reset();
    m_core = 0; m_trip = 0; m_sel = 0; m_fall = 0; m_en = 0; m_pend = 0; m_code = 0;
    for (int i = 0; i < 3; i++) begin m_rise[i] = 0; m_hr[i] = 0; m_hf[i] = 0; end
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit [31:0] d;
    int unsigned seed;
    seed = 32'd4242;
    void'($urandom(seed));
    model_reset();
    bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    smp_valid = 0; smp_code = 0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int idx = 0; idx < 7; idx++) check_reg("R1 reset read", idx);
    check_outs("R1");

    // R2: control field layout
    bus_write(0, 32'hFFFF_FFFF);
    check_reg("R2 ctrl readback", 0);
    check("R2 sensor_sel", {29'd0, sensor_sel}, 32'd7);
    bus_write(0, 32'h0000_0000);

    // R3: threshold layouts
    bus_write(2, 32'hFFFF_FFFF);
    check_reg("R3 rise readback", 2);
    bus_write(3, 32'hA5C3_7E19);
    check_reg("R3 fall readback", 3);

    // R11: enable register stores only event bits
    bus_write(4, 32'hFFFF_FFFF);
    check_reg("R11 enable readback", 4);
    bus_write(4, 32'h0);

    // R7: disabled core ignores samples
    bus_write(2, {8'd200, 8'd100, 8'd50, 8'd0});
    bus_write(3, {8'd180, 8'd90, 8'd45, 8'd0});
    sample(8'd250);
    check_reg("R7 status unchanged", 1);
    check_reg("R7 pending unchanged", 5);

    // R5: rising events
    bus_write(0, 32'h0000_0001);
    sample(8'd40);
    check_reg("R4 status code", 1);
    check_reg("R5 no rise below", 5);
    sample(8'd60);
    check_reg("R5 rise level0", 5);
    bus_write(6, 32'h0111_0111);
    sample(8'd70);
    check_reg("R5 no re-rise while above", 5);
    sample(8'd120);
    check_reg("R5 rise level1", 5);

    // R6: falling events
    sample(8'd30);
    check_reg("R6 fall levels 0 and 1", 5);

    // R8: irq gating, pending independent of enables
    check_outs("R8 disabled");
    bus_write(4, 32'h0001_0000);
    check_outs("R8 enabled fall0");
    bus_write(4, 32'h0000_0100);
    check_outs("R8 enable on empty bit");
    check_reg("R8 pending kept", 5);

    // R9: clear, and set beats clear in the same cycle
    bus_write(6, 32'h0111_0111);
    check_reg("R9 cleared", 5);
    @(negedge clk);
    smp_valid = 1'b1; smp_code = 8'd55;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd6; bus_wdata = 32'h0000_0001;
    @(negedge clk);
    smp_valid = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    model_write(6, 32'h0000_0001, 1'b1);
    model_sample(8'd55);
    check_reg("R9 set wins over clear", 5);

    // R10: trip
    bus_write(0, 32'h0000_1001);
    sample(8'd199);
    check_outs("R10 below trip level");
    sample(8'd200);
    check_outs("R10 at trip level");
    bus_write(0, 32'h0000_0001);
    check_outs("R10 trip disabled");
    bus_write(0, 32'h0000_1001);
    check_outs("R10 trip re-enabled");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op < 6) begin
        sample(8'($urandom_range(0, 255)));
      end else if (op == 6) begin
        bus_write(6, $urandom());
      end else if (op == 7) begin
        bus_write(4, $urandom());
      end else if (op == 8) begin
        bus_write(0, {9'd0, 3'($urandom()), 7'd0, 1'($urandom()), 11'd0,
                      1'($urandom_range(0, 3) != 0)});
      end else begin
        if ($urandom_range(0, 1) == 0) bus_write(2, $urandom());
        else                           bus_write(3, $urandom());
      end
      check_reg("R5 R6 random pending", 5);
      check_reg("R4 random status", 1);
      check_outs("R8 R10 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule